// File: doc/BRIEF.md
# Gate driver fault supervisor

This block sits between the status flags of a bridge gate driver's analog monitors and the gate drive logic. It folds a junction-temperature warning, a logic-supply undervoltage, the regulator undervoltage comparators and one bootstrap failure input per phase into two signals. `fault_n` is an active-low fault flag. `drv_off` forces every gate drive off. Each fault class latches and clears by its own rule. A logic-supply undervoltage wipes every other fault state, and an overtemperature warning only raises the flag.

The active-low `rst_sleep_n` pin passes through a two-flop synchronizer. A short low pulse of at least `PULSE_CYC` synchronized cycles clears the latched faults. Holding the pin low for `SLEEP_CYC` synchronized cycles puts the block to sleep. On wake-up, and after power-on, the drives stay off for `CP_CYC` cycles while the charge pump settles. After power-on the regulator fault also persists until the regulator's upper-threshold flag has been seen once.

Top module: `gdrv_fault_sup`

## Requirements
- R1: While `ot_flag` is 1, `fault_n` is 0 and `drv_off` is not raised by it; `fault_n` returns to 1 once the flag drops, with no latching.
- R2: While `vdd_uv` is 1, `fault_n` is 0 and `drv_off` is 1; both recover when `vdd_uv` returns to 0, with no latching.
- R3: A cycle with `vdd_uv` at 1 erases any latched regulator or bootstrap fault, so after `vdd_uv` drops no fault remains.
- R4: `reg_below_off` at 1 latches a regulator fault (`fault_n` 0, `drv_off` 1) that persists after the flag returns to 0.
- R5: A 0-to-1 transition on any bit of `cmd` (any of the four commands) clears a latched regulator fault only while `reg_below_off` is 0; a held-high command or an edge while still below threshold leaves the fault set.
- R6: A 1 on `boot_fail[p]` latches a bootstrap fault (`fault_n` 0, `drv_off` 1) that command edges do not clear.
- R7: A synchronized low on `rst_sleep_n` lasting at least `PULSE_CYC` but fewer than `SLEEP_CYC` cycles clears latched faults without sleep (`asleep` stays 0). `drv_off` is 1 while the pin is low. A low shorter than `PULSE_CYC` cycles clears nothing.
- R8: A synchronized low lasting `SLEEP_CYC` cycles sets `asleep` to 1. During sleep `drv_off` is 1, `fault_n` is 1 whatever the flags are, and latched faults are cleared.
- R9: After `rst_sleep_n` returns high, `asleep` falls and `drv_off` stays 1 for `CP_CYC` further cycles before the drives may enable.
- R10: After `por_n` releases, the regulator fault (`fault_n` 0, `drv_off` 1) stays until `reg_above_on` is seen at 1. The `CP_CYC` drive holdoff also applies after power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_sleep_n | input | 1 | Asynchronous reset/sleep pin, active low |
| ot_flag | input | 1 | Overtemperature warning |
| vdd_uv | input | 1 | Logic supply below its threshold (hysteresis external) |
| reg_below_off | input | 1 | Regulator below its falling threshold |
| reg_above_on | input | 1 | Regulator above its rising threshold |
| boot_fail | input | NPH | Per-phase bootstrap charge timeout |
| cmd | input | 2*NPH | Gate commands, high and low side per phase, edge-detected |
| fault_n | output | 1 | Fault flag, active low |
| drv_off | output | 1 | Forces all gate drives off |
| asleep | output | 1 | Sleep state indication |

## Verification
A latch that fails to clear shows as `fault_n` stuck low and `drv_off` stuck high within two cycles of the clearing event. A latch that clears too eagerly shows as `fault_n` returning high right after the flag input drops. Errors in the synchronizer or pulse counter show as a wrong `asleep` level, or as faults surviving a reset pulse, within a few cycles of the pin edge. An error in the holdoff counter shows as `drv_off` falling too early or never falling after wake-up, well inside the `CP_CYC` window.

// File: rtl/gdrv_fault_sup.sv
module gdrv_fault_sup #(
  parameter int NPH       = 2,
  parameter int PULSE_CYC = 4,
  parameter int SLEEP_CYC = 16,
  parameter int CP_CYC    = 32
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_sleep_n,
  input  logic             ot_flag,
  input  logic             vdd_uv,
  input  logic             reg_below_off,
  input  logic             reg_above_on,
  input  logic [NPH-1:0]   boot_fail,
  input  logic [2*NPH-1:0] cmd,
  output logic             fault_n,
  output logic             drv_off,
  output logic             asleep
);
  localparam int NCMD = 2 * NPH;
  localparam int LW   = $clog2(SLEEP_CYC + 1);
  localparam int HW   = $clog2(CP_CYC + 1);

  logic [1:0]      pin_sync;
  logic            pin_hi;
  logic [LW-1:0]   lo_cnt;
  logic [HW-1:0]   hold_cnt;
  logic [NCMD-1:0] cmd_q;
  logic            reg_lat;
  logic            pwr_wait;
  logic [NPH-1:0]  boot_lat;
  logic            rst_clr;
  logic            wipe;
  logic            cmd_edge;

  assign pin_hi   = pin_sync[1];
  assign rst_clr  = !pin_hi && (lo_cnt == LW'(PULSE_CYC - 1));
  assign wipe     = vdd_uv || asleep;
  assign cmd_edge = |(cmd & ~cmd_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_sync <= 2'b00;
      cmd_q    <= '0;
    end else begin
      pin_sync <= {pin_sync[0], rst_sleep_n};
      cmd_q    <= cmd;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lo_cnt   <= '0;
      asleep   <= 1'b0;
      hold_cnt <= HW'(CP_CYC);
    end else if (!pin_hi) begin
      if (lo_cnt != LW'(SLEEP_CYC)) lo_cnt <= lo_cnt + 1'b1;
      if (lo_cnt == LW'(SLEEP_CYC - 1)) asleep <= 1'b1;
    end else begin
      lo_cnt <= '0;
      if (asleep) begin
        asleep   <= 1'b0;
        hold_cnt <= HW'(CP_CYC);
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pwr_wait <= 1'b1;
      reg_lat  <= 1'b0;
      boot_lat <= '0;
    end else begin
      if (reg_above_on) pwr_wait <= 1'b0;
      if (wipe) begin
        reg_lat  <= 1'b0;
        boot_lat <= '0;
      end else begin
        if (reg_below_off) reg_lat <= 1'b1;
        else if (rst_clr || cmd_edge) reg_lat <= 1'b0;
        boot_lat <= (rst_clr ? '0 : boot_lat) | boot_fail;
      end
    end
  end

  logic any_lat;
  assign any_lat = reg_lat || pwr_wait || (|boot_lat);

  assign fault_n = asleep || !(ot_flag || vdd_uv || any_lat);
  assign drv_off = asleep || !pin_hi || (hold_cnt != '0) || vdd_uv || any_lat;

endmodule

// File: rtl/gdrv_fault_sup_chk.sv
module gdrv_fault_sup_chk #(
  parameter int NPH = 2
) (
  input logic           clk,
  input logic           por_n,
  input logic           vdd_uv,
  input logic           reg_below_off,
  input logic [NPH-1:0] boot_fail,
  input logic           asleep,
  input logic           drv_off,
  input logic           fault_n,
  input logic           reg_lat,
  input logic [NPH-1:0] boot_lat,
  input logic           rst_clr
);
  logic run_ok;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) run_ok <= 1'b0;
    else        run_ok <= 1'b1;
  end

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    asleep |-> (drv_off && fault_n)); // R8

  AST_VDD_ERASE: assert property (@(posedge clk) disable iff (!por_n)
    vdd_uv |=> (!reg_lat && boot_lat == '0)); // R3

  AST_REG_LATCH: assert property (@(posedge clk) disable iff (!por_n)
    (run_ok && $past(reg_below_off && !vdd_uv && !asleep)) |-> reg_lat); // R4

  AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_clr && !vdd_uv && !asleep) |=> ((boot_lat & $past(boot_lat)) == $past(boot_lat))); // R6

  AST_PULSE_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (rst_clr && boot_fail == '0 && !reg_below_off) |=> (boot_lat == '0 && !reg_lat)); // R7

  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    $fell(asleep) |-> drv_off); // R9
endmodule

bind gdrv_fault_sup gdrv_fault_sup_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .por_n(por_n), .vdd_uv(vdd_uv), .reg_below_off(reg_below_off),
  .boot_fail(boot_fail), .asleep(asleep), .drv_off(drv_off), .fault_n(fault_n),
  .reg_lat(reg_lat), .boot_lat(boot_lat), .rst_clr(rst_clr)
);

// File: tb/gdrv_fault_sup_tb.sv
module gdrv_fault_sup_tb;
  localparam int CLK_PER = 10;
  localparam int NPH     = 2;
  localparam int NROW    = 22;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_sleep_n = 1'b1;
  logic ot_flag = 1'b0, vdd_uv = 1'b0, reg_below_off = 1'b0, reg_above_on = 1'b0;
  logic [NPH-1:0]   boot_fail = '0;
  logic [2*NPH-1:0] cmd = '0;
  logic fault_n, drv_off, asleep;

  int total = 0;
  int bad   = 0;

  always #(CLK_PER/2) clk = ~clk;

  gdrv_fault_sup #(.NPH(NPH)) u_dut (
    .clk(clk), .por_n(por_n), .rst_sleep_n(rst_sleep_n), .ot_flag(ot_flag),
    .vdd_uv(vdd_uv), .reg_below_off(reg_below_off), .reg_above_on(reg_above_on),
    .boot_fail(boot_fail), .cmd(cmd), .fault_n(fault_n), .drv_off(drv_off),
    .asleep(asleep)
  );

  // fields: ot | vdd_uv | reg_below | boot[1:0] | cmd[3:0] | exp fault_n | exp drv_off | req
  localparam logic [14:0] TBL [NROW] = '{
    15'b0_0_0_00_0000_1_0_0001, // R1 idle
    15'b1_0_0_00_0000_0_0_0001, // R1 warn only
    15'b0_0_0_00_0000_1_0_0001, // R1 clears
    15'b0_1_0_00_0000_0_1_0010, // R2
    15'b0_0_0_00_0000_1_0_0010, // R2 clears
    15'b0_0_1_00_0000_0_1_0100, // R4 set
    15'b0_0_0_00_0000_0_1_0100, // R4 held
    15'b0_0_0_00_0001_1_0_0101, // R5 edge clears
    15'b0_0_1_00_0000_0_1_0100, // R4 set again
    15'b0_0_1_00_0100_0_1_0101, // R5 edge while below
    15'b0_0_0_00_0100_0_1_0101, // R5 held high, no edge
    15'b0_0_0_00_0000_0_1_0101, // R5 falling, no edge
    15'b0_0_0_00_1000_1_0_0101, // R5 edge clears
    15'b0_0_0_01_0000_0_1_0110, // R6 set
    15'b0_0_0_00_1111_0_1_0110, // R6 edges do not clear
    15'b0_1_0_00_0000_0_1_0011, // R3 vdd low
    15'b0_0_0_00_0000_1_0_0011, // R3 erased
    15'b0_0_1_10_0000_0_1_0100, // R4 both latched
    15'b0_1_0_00_0000_0_1_0011, // R3 vdd low
    15'b0_0_0_00_0000_1_0_0011, // R3 erased
    15'b0_0_0_10_0000_0_1_0110, // R6 set
    15'b0_0_0_00_0000_0_1_0110  // R6 held
  };

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R10", "reset fault_n", fault_n, 1'b0);
    chk("R10", "reset drv_off", drv_off, 1'b1);
    chk("R8", "reset asleep", asleep, 1'b0);
    por_n = 1'b1;
    cyc(40);
    chk("R10", "waiting fault_n", fault_n, 1'b0);
    chk("R10", "waiting drv_off", drv_off, 1'b1);
    reg_above_on = 1'b1;
    cyc(1);
    reg_above_on = 1'b0;
    cyc(2);
    chk("R10", "ready fault_n", fault_n, 1'b1);
    chk("R10", "ready drv_off", drv_off, 1'b0);

    for (int i = 0; i < NROW; i++) begin
      {ot_flag, vdd_uv, reg_below_off, boot_fail, cmd} = TBL[i][14:6];
      cyc(2);
      total++;
      if (fault_n !== TBL[i][5] || drv_off !== TBL[i][4]) begin
        bad++;
        $display("FAIL R%0d row %0d: actual=%b%b expected=%b%b", TBL[i][3:0], i,
                 fault_n, drv_off, TBL[i][5], TBL[i][4]);
      end
    end

    // R7: too-short pulse keeps the bootstrap latch
    rst_sleep_n = 1'b0;
    cyc(2);
    rst_sleep_n = 1'b1;
    cyc(6);
    chk("R7", "short pulse fault_n", fault_n, 1'b0);

    // R7: proper pulse clears without sleep
    rst_sleep_n = 1'b0;
    cyc(6);
    chk("R7", "pulse drv_off", drv_off, 1'b1);
    chk("R7", "pulse asleep", asleep, 1'b0);
    cyc(2);
    rst_sleep_n = 1'b1;
    cyc(5);
    chk("R7", "after pulse fault_n", fault_n, 1'b1);
    chk("R7", "after pulse drv_off", drv_off, 1'b0);
    chk("R7", "after pulse asleep", asleep, 1'b0);

    // R8: sleep with latched faults and a warning present
    boot_fail = 2'b01;
    reg_below_off = 1'b1;
    cyc(1);
    boot_fail = 2'b00;
    reg_below_off = 1'b0;
    cyc(1);
    rst_sleep_n = 1'b0;
    ot_flag = 1'b1;
    cyc(30);
    chk("R8", "sleep asleep", asleep, 1'b1);
    chk("R8", "sleep fault_n", fault_n, 1'b1);
    chk("R8", "sleep drv_off", drv_off, 1'b1);
    ot_flag = 1'b0;
    rst_sleep_n = 1'b1;
    cyc(6);
    chk("R9", "wake asleep", asleep, 1'b0);
    chk("R9", "wake holdoff drv_off", drv_off, 1'b1);
    chk("R8", "wake latches cleared", fault_n, 1'b1);
    cyc(40);
    chk("R9", "holdoff done drv_off", drv_off, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule